// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block gathers the four interrupt classes of a UART and presents the most urgent enabled one as a 4-bit identification code, together with a single interrupt request line. The four classes, from most to least urgent, are: receive line errors, received data (including the character timeout), transmit holding register empty, and modem input changes. Event-type sources are held in pending latches until the matching register access clears them. Received-data availability is a level that the receive path supplies directly.

The surrounding register file passes in access strobes. These are reads of the identification, line status, receive buffer and modem status registers, and writes to the transmit holding register. The identification code and the interrupt line are registered. Both reflect the inputs sampled at the previous clock edge. A read of the identification register returns the code held at that moment. The read clears the transmit-empty source only when that code names it.

Top module: `irq_prio_ident`

## Requirements
- R1: After a synchronous reset, `ident_code` is 4'b0001 and `irq` is 0.
- R2: Both outputs are registered. Inputs sampled at a clock edge appear at the outputs after that edge. `irq` is always the inverse of `ident_code[0]`. The code 4'b0001 means that nothing is pending.
- R3: A pulse on `line_err_evt` latches a line-error source, reported as 4'b0110. It stays pending until `rd_line` is pulsed.
- R4: While `rx_avail` is high and no line error is shown, the code is 4'b0100. It clears as soon as `rx_avail` falls.
- R5: A pulse on `rx_timeout_evt` latches a timeout source. With `fifo_mode` high it is reported as 4'b1100. A `rd_rxbuf` pulse clears it.
- R6: With `fifo_mode` low, bit 3 of the code is always 0, so a pending timeout is reported as 4'b0100.
- R7: A pulse on `thre_evt` latches a transmit-empty source, reported as 4'b0010. A `wr_thr` pulse clears it.
- R8: A `rd_ident` pulse clears the transmit-empty source only when `ident_code` is 4'b0010 in that cycle. Otherwise the source stays pending.
- R9: A pulse on `modem_chg_evt` latches a modem source, reported as 4'b0000. A `rd_modem` pulse clears it.
- R10: When several sources are pending, the order is: line error, then timeout or received data, then transmit empty, then modem.
- R11: `src_en` bit 0 enables line error, bit 1 received data and timeout, bit 2 transmit empty, and bit 3 modem. A disabled source never appears in the code. Its latch still records events, so enabling it later reveals a source that is still pending.
- R12: An event that arrives in the same cycle as its own clear strobe leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | FIFO mode active; allows code bit 3 |
| src_en | input | 4 | Per-class enables (line, rx, thre, modem) |
| line_err_evt | input | 1 | Pulse: overrun, parity, framing or break seen |
| rx_avail | input | 1 | Level: received data available |
| rx_timeout_evt | input | 1 | Pulse: receive character timeout |
| thre_evt | input | 1 | Pulse: transmit holding register became empty |
| modem_chg_evt | input | 1 | Pulse: change on a modem control input |
| rd_ident | input | 1 | Strobe: identification register read |
| rd_line | input | 1 | Strobe: line status register read |
| rd_rxbuf | input | 1 | Strobe: receive buffer read |
| rd_modem | input | 1 | Strobe: modem status register read |
| wr_thr | input | 1 | Strobe: transmit holding register write |
| ident_code | output | 4 | Registered identification code |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The bench aims at the conditional clear of the transmit-empty source. An identification read made while a line error is displayed must leave transmit-empty pending; a design that clears it unconditionally would skip straight to idle once the line error is cleared. It pulses events in the same cycle as their clear strobes. A design that lets the clear win would lose the interrupt and show 0001. It also toggles FIFO mode under a pending timeout, where a leaked bit 3 would show 1100 outside FIFO mode. Finally, it hides sources behind their enables and unmasks them later, where a design that gates the latches would never reveal them.

// File: rtl/irq_ident_pkg.sv
package irq_ident_pkg;
  localparam int NUM_LATCHED = 4;
  localparam int CODE_W      = 4;

  // latch indices, in priority order
  localparam int IX_LINE  = 0;
  localparam int IX_RXTO  = 1;
  localparam int IX_THRE  = 2;
  localparam int IX_MODEM = 3;

  localparam logic [CODE_W-1:0] ID_NONE  = 4'b0001;
  localparam logic [CODE_W-1:0] ID_LINE  = 4'b0110;
  localparam logic [CODE_W-1:0] ID_RXD   = 4'b0100;
  localparam logic [CODE_W-1:0] ID_RXTO  = 4'b1100;
  localparam logic [CODE_W-1:0] ID_THRE  = 4'b0010;
  localparam logic [CODE_W-1:0] ID_MODEM = 4'b0000;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_nxt
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // a new event outranks a clear arriving in the same cycle
    assign pend_nxt[i] = set_i[i] | (pend_q[i] & ~clr_i[i]);

    always_ff @(posedge clk) begin
      if (rst) pend_q[i] <= 1'b0;
      else     pend_q[i] <= pend_nxt[i];
    end

    a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> pend_q[i]);
    a_r3_hold_until_clear: assert property (@(posedge clk) disable iff (rst)
      (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !pend_q[i]);
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_ident_pkg::*;
(
  input  logic              line_v,
  input  logic              rxto_v,
  input  logic              rxd_v,
  input  logic              thre_v,
  input  logic              modem_v,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    if (line_v)       code = ID_LINE;
    else if (rxto_v)  code = ID_RXTO;
    else if (rxd_v)   code = ID_RXD;
    else if (thre_v)  code = ID_THRE;
    else if (modem_v) code = ID_MODEM;
    else              code = ID_NONE;
  end
endmodule

// File: rtl/irq_prio_ident.sv
module irq_prio_ident
  import irq_ident_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        fifo_mode,
  input  logic [3:0]  src_en,
  input  logic        line_err_evt,
  input  logic        rx_avail,
  input  logic        rx_timeout_evt,
  input  logic        thre_evt,
  input  logic        modem_chg_evt,
  input  logic        rd_ident,
  input  logic        rd_line,
  input  logic        rd_rxbuf,
  input  logic        rd_modem,
  input  logic        wr_thr,
  output logic [3:0]  ident_code,
  output logic        irq
);
  logic [NUM_LATCHED-1:0] set_v, clr_v, pend_nxt;
  logic [CODE_W-1:0]      code_d;
  logic                   shows_thre;

  // the clear uses the code held now, not the one being computed
  assign shows_thre = (ident_code == ID_THRE);

  always_comb begin
    set_v           = '0;
    clr_v           = '0;
    set_v[IX_LINE]  = line_err_evt;
    clr_v[IX_LINE]  = rd_line;
    set_v[IX_RXTO]  = rx_timeout_evt;
    clr_v[IX_RXTO]  = rd_rxbuf;
    set_v[IX_THRE]  = thre_evt;
    clr_v[IX_THRE]  = wr_thr | (rd_ident & shows_thre);
    set_v[IX_MODEM] = modem_chg_evt;
    clr_v[IX_MODEM] = rd_modem;
  end

  irq_pend_bank #(.N(NUM_LATCHED)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .set_i    (set_v),
    .clr_i    (clr_v),
    .pend_nxt (pend_nxt)
  );

  irq_prio_enc u_enc (
    .line_v  (src_en[0] & pend_nxt[IX_LINE]),
    .rxto_v  (src_en[1] & fifo_mode & pend_nxt[IX_RXTO]),
    .rxd_v   (src_en[1] & (rx_avail | pend_nxt[IX_RXTO])),
    .thre_v  (src_en[2] & pend_nxt[IX_THRE]),
    .modem_v (src_en[3] & pend_nxt[IX_MODEM]),
    .code    (code_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ident_code <= ID_NONE;
      irq        <= 1'b0;
    end else begin
      ident_code <= code_d;
      irq        <= ~code_d[0];
    end
  end

  a_r2_irq_tracks_code: assert property (@(posedge clk) disable iff (rst)
    irq == !ident_code[0]);
  a_r6_bit3_fifo_only: assert property (@(posedge clk) disable iff (rst)
    !$past(fifo_mode) |-> !ident_code[3]);
  a_r11_masked_line: assert property (@(posedge clk) disable iff (rst)
    (ident_code == ID_LINE) |-> $past(src_en[0]));
  a_r8_ident_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_ident && ident_code == ID_THRE && !thre_evt) |=> ident_code != ID_THRE);
endmodule

// File: tb/irq_prio_ident_test.sv
module irq_prio_ident_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_mode = 1'b0;
  logic [3:0] src_en = 4'b0000;
  logic       line_err_evt = 0, rx_avail = 0, rx_timeout_evt = 0;
  logic       thre_evt = 0, modem_chg_evt = 0;
  logic       rd_ident = 0, rd_line = 0, rd_rxbuf = 0, rd_modem = 0, wr_thr = 0;
  logic [3:0] ident_code;
  logic       irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ident uut (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .src_en(src_en),
    .line_err_evt(line_err_evt), .rx_avail(rx_avail),
    .rx_timeout_evt(rx_timeout_evt), .thre_evt(thre_evt),
    .modem_chg_evt(modem_chg_evt), .rd_ident(rd_ident), .rd_line(rd_line),
    .rd_rxbuf(rd_rxbuf), .rd_modem(rd_modem), .wr_thr(wr_thr),
    .ident_code(ident_code), .irq(irq)
  );

  task automatic chk(input logic [3:0] exp, input string req);
    n_run++;
    if (ident_code !== exp || irq !== ~exp[0]) begin
      n_fail++;
      $display("FAIL %s: code=%b irq=%b expected code=%b irq=%b",
               req, ident_code, irq, exp, ~exp[0]);
    end
  endtask

  // all inputs are driven right after a falling edge and then held for one
  // full cycle; the outputs are read at the following falling edge
  task automatic tick();
    @(negedge clk);
    line_err_evt = 0; rx_timeout_evt = 0; thre_evt = 0; modem_chg_evt = 0;
    rd_ident = 0; rd_line = 0; rd_rxbuf = 0; rd_modem = 0; wr_thr = 0;
  endtask

  task automatic t_reset();
    chk(4'b0001, "R1");
    tick(); chk(4'b0001, "R2 idle");
  endtask

  task automatic t_line();
    line_err_evt = 1; tick(); chk(4'b0110, "R3 set");
    tick(); chk(4'b0110, "R3 held");
    rd_line = 1; line_err_evt = 1; tick(); chk(4'b0110, "R12 line set wins");
    rd_line = 1; tick(); chk(4'b0001, "R3 cleared");
  endtask

  task automatic t_rx();
    rx_avail = 1; tick(); chk(4'b0100, "R4 data");
    rx_avail = 0; tick(); chk(4'b0001, "R4 drop");
  endtask

  task automatic t_timeout();
    rx_timeout_evt = 1; tick(); chk(4'b1100, "R5 timeout");
    fifo_mode = 0; tick(); chk(4'b0100, "R6 bit3 forced 0");
    fifo_mode = 1; tick(); chk(4'b1100, "R5 back in fifo");
    rd_rxbuf = 1; tick(); chk(4'b0001, "R5 cleared");
  endtask

  task automatic t_thre();
    thre_evt = 1; tick(); chk(4'b0010, "R7 set");
    wr_thr = 1; tick(); chk(4'b0001, "R7 write clears");
    thre_evt = 1; tick(); chk(4'b0010, "R8 set");
    rd_ident = 1; tick(); chk(4'b0001, "R8 ident read clears");
    line_err_evt = 1; thre_evt = 1; tick(); chk(4'b0110, "R8 line shown");
    rd_ident = 1; tick(); chk(4'b0110, "R8 still line");
    rd_line = 1; tick(); chk(4'b0010, "R8 thre survived read");
    rd_ident = 1; thre_evt = 1; tick(); chk(4'b0010, "R12 thre set wins");
    wr_thr = 1; tick(); chk(4'b0001, "R7 final clear");
  endtask

  task automatic t_modem();
    modem_chg_evt = 1; tick(); chk(4'b0000, "R9 set");
    rd_modem = 1; tick(); chk(4'b0001, "R9 cleared");
  endtask

  task automatic t_prio();
    line_err_evt = 1; thre_evt = 1; modem_chg_evt = 1; rx_avail = 1;
    tick(); chk(4'b0110, "R10 line first");
    rd_line = 1; tick(); chk(4'b0100, "R10 rx second");
    rx_avail = 0; tick(); chk(4'b0010, "R10 thre third");
    wr_thr = 1; tick(); chk(4'b0000, "R10 modem last");
    rd_modem = 1; tick(); chk(4'b0001, "R10 empty");
  endtask

  task automatic t_mask();
    src_en = 4'b1110; line_err_evt = 1; tick(); chk(4'b0001, "R11 line masked");
    src_en = 4'b1111; tick(); chk(4'b0110, "R11 line unmasked");
    rd_line = 1; tick(); chk(4'b0001, "R11 line cleared");
    src_en = 4'b1011; thre_evt = 1; tick(); chk(4'b0001, "R11 thre masked");
    rd_ident = 1; tick(); chk(4'b0001, "R11 read while hidden");
    src_en = 4'b1111; tick(); chk(4'b0010, "R11 thre revealed");
    wr_thr = 1; tick(); chk(4'b0001, "R11 thre cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(4'b0001, "R1 in reset");
    rst = 0; src_en = 4'b1111; fifo_mode = 1;
    t_reset();
    t_line();
    t_rx();
    t_timeout();
    t_thre();
    t_modem();
    t_prio();
    t_mask();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule